// File: doc/BRIEF.md
# Chainable Quad-Channel Converter Serial Front End

This block models the digital input side of a four-channel digital-to-analog converter that takes commands over a serial link and can be chained with identical devices. While the active-low select is held low, every rising edge of the serial clock pushes one data bit into a 16-bit word register. The bit pushed out of the far end of that register appears on a serial output pin, so the next device in a chain can take its input from this pin. In a chain of N devices the host sends 16·N bits, starting with the word meant for the last device. Each device ends up holding the last 16 bits that reached it.

When the select returns high, the held word is decoded. The first four bits received form a channel selector. The next ten bits are a code value. The final two bits carry no meaning. A selector from 1 to 4 loads the code into one of four channel registers. Any other selector leaves all four unchanged. The four channel codes are output side by side on a single bus.

All inputs are sampled with a fast local clock. The serial clock and the select are treated as slow signals that are already synchronous to this clock, and the block acts on their edges.

Top module: `qdac_serial_front`

## Requirements
- R1: During and after reset, all four channel codes are zero and the serial output is low.
- R2: While select is low, each rising serial-clock edge shifts `sdi` into the word register, with the first-received bit ending up as the selector MSB. On each falling serial-clock edge while select is low, `sdo` takes the bit that was shifted in 16 rising edges earlier, or the bit held from before the frame if fewer than 16 edges have occurred.
- R3: While select is high, serial-clock edges change neither the held word nor `sdo`.
- R4: On the rising edge of select, a selector value s in 1..4 (held word bits 15:12) loads held word bits 11:2 into `ch_codes[(s-1)*10 +: 10]`. Held word bits 1:0 have no effect.
- R5: A selector of 0 leaves all four channel codes unchanged.
- R6: Selector values 5 to 15 leave all four channel codes unchanged.
- R7: At most one channel code changes per select cycle. If more than 16 bits are sent, only the last 16 bits decide which channel changes and to what value.
- R8: Channel codes change only in response to a rising edge of select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low select; its rising edge applies the held word |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next device in a chain |
| ch_codes | output | 40 | Four 10-bit channel codes; channel k occupies bits [k*10 +: 10] |

## Verification
The testbench builds the block with its default parameters: a 4-bit selector, 10-bit codes and 2 padding bits, which gives a 16-bit word and four channels. With these values, every selector value from 0 to 15 can be reached by random stimulus. Frame lengths from 8 to 40 bits exercise partial frames, exact 16-bit frames, and frames long enough to pass a full word through to `sdo`, as in a two-device chain. Serial-clock toggling while select is high is mixed in, and the frames that follow show whether the held word was disturbed.

// File: rtl/qdac_serial_front.sv
module qdac_serial_front #(
  parameter int AW   = 4,
  parameter int CW   = 10,
  parameter int PADW = 2,
  parameter int NCH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  output logic [NCH*CW-1:0] ch_codes
);
  localparam int WW = AW + CW + PADW;

  logic          sck_d, cs_d;
  logic [WW-1:0] sr;

  wire sck_rise = sck & ~sck_d & ~cs_n;
  wire sck_fall = ~sck & sck_d & ~cs_n;
  wire cs_rise  = cs_n & ~cs_d;

  wire [AW-1:0] sel  = sr[WW-1 -: AW];
  wire [CW-1:0] code = sr[WW-1-AW -: CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (sck_rise) sr <= {sr[WW-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo <= 1'b0;
    else if (sck_fall) sdo <= sr[WW-1];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ch_codes[i*CW +: CW] <= '0;
      else if (cs_rise && sel == AW'(i + 1))
        ch_codes[i*CW +: CW] <= code;
    end
  end
endmodule

module qdac_serial_front_chk #(
  parameter int AW   = 4,
  parameter int CW   = 10,
  parameter int PADW = 2,
  parameter int NCH  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sck,
  input logic                       cs_n,
  input logic                       sdo,
  input logic [NCH*CW-1:0]          ch_codes,
  input logic [AW+CW+PADW-1:0]      sr
);
  localparam int WW = AW + CW + PADW;

  logic [NCH-1:0] changed;
  logic [NCH*CW-1:0] prev_codes;
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_codes <= '0;
      started    <= 1'b0;
    end else begin
      prev_codes <= ch_codes;
      started    <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_c
    assign changed[i] = started && (prev_codes[i*CW +: CW] != ch_codes[i*CW +: CW]);

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !$past(cs_n) && sr[WW-1 -: AW] == AW'(i + 1))
      |=> ch_codes[i*CW +: CW] == $past(sr[WW-1-AW -: CW]));
  end

  a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(changed) <= 1);

  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sr));

  a_r5_r6_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) &&
     (sr[WW-1 -: AW] == '0 || sr[WW-1 -: AW] > AW'(NCH)))
    |=> $stable(ch_codes));

  a_r8_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !$past(cs_n)) |=> $stable(ch_codes));

  a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(!sck) && $past(sck, 2) && $past(!cs_n)));
endmodule

bind qdac_serial_front qdac_serial_front_chk #(
  .AW(AW), .CW(CW), .PADW(PADW), .NCH(NCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
  .sdo(sdo), .ch_codes(ch_codes), .sr(sr)
);

// File: tb/sim_qdac_serial_front.sv
module sim_qdac_serial_front;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic        sdo;
  logic [39:0] ch_codes;

  int compared = 0, mismatched = 0;
  logic [15:0] m_sr = '0;
  logic        m_sdo = 1'b0;
  logic [39:0] m_codes = '0;

  always #10 clk = ~clk;

  qdac_serial_front u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sdi(sdi), .sdo(sdo), .ch_codes(ch_codes)
  );

  function automatic logic [39:0] apply_word(logic [39:0] c, logic [15:0] w);
    logic [3:0] s = w[15:12];
    if (s >= 4'd1 && s <= 4'd4) c[(s-1)*10 +: 10] = w[11:2];
    return c;
  endfunction

  function automatic string tag_for(logic [15:0] w);
    if (w[15:12] == 4'd0) return "R5";
    if (w[15:12] > 4'd4)  return "R6";
    return "R4/R7";
  endfunction

  task automatic check_codes(string tag);
    compared++;
    if (ch_codes !== m_codes) begin
      mismatched++;
      $display("FAIL %s codes actual=%h expected=%h", tag, ch_codes, m_codes);
    end
  endtask

  task automatic check_sdo(string tag);
    compared++;
    if (sdo !== m_sdo) begin
      mismatched++;
      $display("FAIL %s sdo actual=%b expected=%b", tag, sdo, m_sdo);
    end
  endtask

  task automatic bit_out(logic b, logic active);
    sdi = b;
    sck = 1'b1;
    repeat (3) @(negedge clk);
    if (active) m_sr = {m_sr[14:0], b};
    sck = 1'b0;
    repeat (3) @(negedge clk);
    if (active) m_sdo = m_sr[15];
    check_sdo(active ? "R2" : "R3");
  endtask

  task automatic frame(logic [63:0] bits, int n);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      bit_out(bits[k], 1'b1);
      if (k == n / 2) check_codes("R8");
    end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    m_codes = apply_word(m_codes, m_sr);
    check_codes(tag_for(m_sr));
  endtask

  task automatic idle_toggle(int n);
    for (int k = 0; k < n; k++) bit_out(1'($urandom), 1'b0);
    check_codes("R3");
  endtask

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_codes("R1");
    check_sdo("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_codes("R1");

    frame({48'd0, 4'd1, 10'h3FF, 2'b11}, 16);
    frame({48'd0, 4'd4, 10'h155, 2'b01}, 16);
    frame({48'd0, 4'd0, 10'h2AA, 2'b00}, 16);
    frame({48'd0, 4'd9, 10'h0F0, 2'b10}, 16);
    frame({48'd0, 4'd15, 10'h123, 2'b00}, 16);
    frame({32'd0, 4'd2, 10'h111, 2'b00, 4'd3, 10'h222, 2'b11}, 32);
    idle_toggle(6);
    frame({48'd0, 4'd2, 10'h0AB, 2'b00}, 16);
    frame({56'd0, 8'hA5}, 8);

    for (int f = 0; f < 60; f++) begin
      logic [63:0] b = {$urandom, $urandom};
      int n = 8 + int'($urandom % 33);
      if ($urandom % 3 == 0) b[n-1 -: 4] = 4'(1 + $urandom % 4);
      frame(b, n);
      if ($urandom % 4 == 0) idle_toggle(1 + int'($urandom % 4));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule